// File: doc/BRIEF.md
# Open-Loop Ramp Rate Calibrator

This block tunes the open-loop acceleration of a sensorless spindle commutation oscillator before a motor is spun up. On a start request it resets the oscillator for a minimum time. It then releases that reset, keeps the motor current command forced off, and drives the ramp-setting PWM at half duty. While the oscillator accelerates, the block watches its tach output. The oscillator's frequency slope shows up as the shrinkage between two consecutive oscillator periods, and the block measures it there.

From that shrinkage and a desired shrinkage supplied by the system, the block computes a corrected ramp PWM duty. The formula is half duty scaled by the desired difference over the measured difference. A restoring divider does the division over several cycles, and the result is clamped to the duty word range. Two events abort a run and leave the duty at half: a measured difference that is zero or negative, and tach periods that do not arrive in time. Each one sets its own error flag. After a run ends, the ramp PWM keeps running at the computed duty, and the normal start-up sequence uses it for open-loop stepping.

Top module: `rampcal_top`

## Requirements
- R1: On an accepted start request, `chipResetN` goes low for exactly RESET_CYC = ceil(CLK_HZ / 200000) clock cycles, which is at least 5 µs, and then returns high for the rest of the run.
- R2: While `calBusy` is high, `currentHold` is 1 and `dutyWord` equals half scale (2^(DW-1), 128 for DW = 8). While `calBusy` is low, `currentHold` is 0.
- R3: `rampPwm` is high for exactly `dutyWord` cycles out of every 2^DW consecutive cycles while `dutyWord` is steady.
- R4: The measured difference is P1 − P2. P1 is the spacing in clock cycles between the first and second rising edges of `tachIn` after `chipResetN` is released, and P2 is the spacing between the second and third. Edges seen while `chipResetN` is low are ignored.
- R5: On a positive measured difference, `dutyWord` becomes floor(desiredDiff × 2^(DW-1) / (P1 − P2)).
- R6: A quotient above 2^DW − 1 saturates `dutyWord` to 2^DW − 1.
- R7: A measured difference of zero or below ends the run with `errBadDiff` = 1, `errTimeout` = 0 and `dutyWord` at half scale.
- R8: If the third edge is not captured within `timeoutLimit` cycles of reset release, the run ends with `errTimeout` = 1, `errBadDiff` = 0 and `dutyWord` at half scale.
- R9: `calDone` rises only at the end of a run and holds until the next accepted start. A start request while `calBusy` is high is ignored: reset is not pulsed again and the result does not change.
- R10: After `rstN` reset: `chipResetN` = 1, `currentHold` = 0, `calBusy` = 0, `calDone` = 0, both error flags 0, and `dutyWord` at half scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a calibration run |
| tachIn | input | 1 | Oscillator tach pulse, asynchronous, rising edges counted |
| desiredDiff | input | PW | Desired period shrinkage in clock cycles |
| timeoutLimit | input | TW | Cycles allowed from reset release to the third edge |
| chipResetN | output | 1 | Active-low reset to the oscillator |
| currentHold | output | 1 | 1 forces the motor current command to zero |
| rampPwm | output | 1 | Ramp-setting PWM |
| dutyWord | output | DW | Active PWM duty, out of 2^DW |
| calBusy | output | 1 | Run in progress |
| calDone | output | 1 | Run finished, result valid |
| errBadDiff | output | 1 | Measured difference was not positive |
| errTimeout | output | 1 | Tach periods did not arrive in time |

## Verification
The cases hardest to reach from the ports are a start request re-issued in the middle of a measurement and tach activity during the reset hold. In both, something happens at the inputs that must leave no trace. The stimulus pulses `startReq` between the second and third tach edges. It then checks that the total low time of `chipResetN` in that run is still a single window and that the duty matches an undisturbed run. In another run, a short tach pulse lands inside the reset hold; a changed result would show that pulse counted as the first edge. The tach edges are placed at exact cycle spacings, so each expected quotient, including the saturating and zero-numerator cases, is known exactly ahead of time.

// File: rtl/rampcal_pkg.sv
package rampcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTHOLD,
    ST_MEASURE,
    ST_EVAL,
    ST_DIVIDE,
    ST_DONE
  } calState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic measClr;    // clear period capture
    logic measRun;    // capture window open
    logic divStart;   // launch divider
    logic loadCal;    // take divider result as duty
    logic forceHalf;  // force duty to half scale
  } calStrobe_t;

endpackage

// File: rtl/rampcal_ctrl.sv
module rampcal_ctrl
  import rampcal_pkg::*;
#(
  parameter int RESET_CYC = 50,
  parameter int TW        = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [TW-1:0] timeoutLimit,
  input  logic          measDone,
  input  logic          diffBad,
  input  logic          divDone,
  output calStrobe_t    strb,
  output logic          chipResetN,
  output logic          currentHold,
  output logic          calBusy,
  output logic          calDone,
  output logic          errBadDiff,
  output logic          errTimeout
);

  localparam int RW = $clog2(RESET_CYC + 1);
  localparam logic [RW-1:0] RST_LAST = RW'(RESET_CYC - 1);

  calState_t     state, stNext;
  logic [RW-1:0] rstCnt;
  logic [TW-1:0] toCnt;
  logic          timedOut;
  logic          startOk;

  assign startOk  = startReq && (state == ST_IDLE || state == ST_DONE);
  assign timedOut = (state == ST_MEASURE) && !measDone && (toCnt >= timeoutLimit);

  always_comb begin
    stNext = state;
    strb   = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (startReq) begin
          stNext         = ST_RSTHOLD;
          strb.measClr   = 1'b1;
          strb.forceHalf = 1'b1;
        end
      end
      ST_RSTHOLD: begin
        if (rstCnt == RST_LAST) begin
          stNext       = ST_MEASURE;
          strb.measClr = 1'b1;
        end
      end
      ST_MEASURE: begin
        strb.measRun = 1'b1;
        if (measDone) begin
          stNext = ST_EVAL;
        end else if (timedOut) begin
          stNext         = ST_DONE;
          strb.forceHalf = 1'b1;
        end
      end
      ST_EVAL: begin
        if (diffBad) begin
          stNext         = ST_DONE;
          strb.forceHalf = 1'b1;
        end else begin
          stNext        = ST_DIVIDE;
          strb.divStart = 1'b1;
        end
      end
      ST_DIVIDE: begin
        if (divDone) begin
          stNext       = ST_DONE;
          strb.loadCal = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      rstCnt     <= '0;
      toCnt      <= '0;
      calDone    <= 1'b0;
      errBadDiff <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      state <= stNext;

      if (state == ST_RSTHOLD) rstCnt <= rstCnt + 1'b1;
      else                     rstCnt <= '0;

      if (state == ST_MEASURE) begin
        if (toCnt != '1) toCnt <= toCnt + 1'b1;
      end else begin
        toCnt <= '0;
      end

      if (startOk) begin
        calDone    <= 1'b0;
        errBadDiff <= 1'b0;
        errTimeout <= 1'b0;
      end else begin
        if (stNext == ST_DONE && state != ST_DONE) calDone <= 1'b1;
        if (state == ST_EVAL && diffBad)           errBadDiff <= 1'b1;
        if (timedOut)                              errTimeout <= 1'b1;
      end
    end
  end

  assign calBusy     = (state == ST_RSTHOLD) || (state == ST_MEASURE) ||
                       (state == ST_EVAL)    || (state == ST_DIVIDE);
  assign chipResetN  = (state != ST_RSTHOLD);
  assign currentHold = calBusy;

endmodule

// File: rtl/rampcal_dp.sv
module rampcal_dp
  import rampcal_pkg::*;
#(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  calStrobe_t    strb,
  input  logic          tachIn,
  input  logic [PW-1:0] desiredDiff,
  output logic          measDone,
  output logic          diffBad,
  output logic          divDone,
  output logic          rampPwm,
  output logic [DW-1:0] dutyWord
);

  localparam int NW = PW + DW - 1;          // dividend / quotient width
  localparam int CW = $clog2(NW + 1);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  // Tach synchroniser and rising-edge detect
  logic [2:0] tSync;
  logic       tachEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tSync <= '0;
    else       tSync <= {tSync[1:0], tachIn};
  end
  assign tachEdge = tSync[1] & ~tSync[2];

  // Period capture
  logic [1:0]    edgeNum;
  logic [PW-1:0] perCnt, perOne, perTwo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeNum  <= '0;
      perCnt   <= '0;
      perOne   <= '0;
      perTwo   <= '0;
      measDone <= 1'b0;
    end else if (strb.measClr) begin
      edgeNum  <= '0;
      perCnt   <= '0;
      perOne   <= '0;
      perTwo   <= '0;
      measDone <= 1'b0;
    end else begin
      measDone <= 1'b0;
      if (strb.measRun) begin
        if (tachEdge) begin
          case (edgeNum)
            2'd0: begin
              perCnt  <= PW'(1);
              edgeNum <= 2'd1;
            end
            2'd1: begin
              perOne  <= perCnt;
              perCnt  <= PW'(1);
              edgeNum <= 2'd2;
            end
            2'd2: begin
              perTwo   <= perCnt;
              measDone <= 1'b1;
              edgeNum  <= 2'd3;
            end
            default: ;
          endcase
        end else if (edgeNum != 2'd0 && perCnt != '1) begin
          perCnt <= perCnt + 1'b1;
        end
      end
    end
  end

  logic [PW:0] diffS;
  assign diffS   = {1'b0, perOne} - {1'b0, perTwo};
  assign diffBad = diffS[PW] | (diffS == '0);

  // Restoring divider: (desiredDiff << (DW-1)) / diff
  logic [NW-1:0] divNum, divQuo;
  logic [PW-1:0] divRem, divDen;
  logic [CW-1:0] divCnt;
  logic          divBusy;
  logic [PW:0]   trial, trialSub;
  logic          trialGe;

  assign trial    = {divRem, divNum[NW-1]};
  assign trialSub = trial - {1'b0, divDen};
  assign trialGe  = (trial >= {1'b0, divDen});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divNum  <= '0;
      divQuo  <= '0;
      divRem  <= '0;
      divDen  <= '0;
      divCnt  <= '0;
      divBusy <= 1'b0;
      divDone <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (strb.divStart) begin
        divNum  <= {desiredDiff, {(DW-1){1'b0}}};
        divQuo  <= '0;
        divRem  <= '0;
        divDen  <= diffS[PW-1:0];
        divCnt  <= CW'(NW);
        divBusy <= 1'b1;
      end else if (divBusy) begin
        divNum <= {divNum[NW-2:0], 1'b0};
        divQuo <= {divQuo[NW-2:0], trialGe};
        divRem <= trialGe ? trialSub[PW-1:0] : trial[PW-1:0];
        divCnt <= divCnt - 1'b1;
        if (divCnt == CW'(1)) begin
          divBusy <= 1'b0;
          divDone <= 1'b1;
        end
      end
    end
  end

  // Saturate quotient to duty range
  logic [DW-1:0] quoSat;
  assign quoSat = (|divQuo[NW-1:DW]) ? '1 : divQuo[DW-1:0];

  logic [DW-1:0] dutyReg, pwmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyReg <= HALF;
      pwmCnt  <= '0;
      rampPwm <= 1'b0;
    end else begin
      if (strb.forceHalf)    dutyReg <= HALF;
      else if (strb.loadCal) dutyReg <= quoSat;
      pwmCnt  <= pwmCnt + 1'b1;
      rampPwm <= (pwmCnt < dutyReg);
    end
  end

  assign dutyWord = dutyReg;

endmodule

// File: rtl/rampcal_top.sv
module rampcal_top
  import rampcal_pkg::*;
#(
  parameter int CLK_HZ = 10_000_000,
  parameter int PW     = 16,
  parameter int DW     = 8,
  parameter int TW     = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          tachIn,
  input  logic [PW-1:0] desiredDiff,
  input  logic [TW-1:0] timeoutLimit,
  output logic          chipResetN,
  output logic          currentHold,
  output logic          rampPwm,
  output logic [DW-1:0] dutyWord,
  output logic          calBusy,
  output logic          calDone,
  output logic          errBadDiff,
  output logic          errTimeout
);

  localparam int RAW_CYC   = (CLK_HZ + 199_999) / 200_000;   // 5 us
  localparam int RESET_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  calStrobe_t strb;
  logic       measDone, diffBad, divDone;

  rampcal_ctrl #(.RESET_CYC(RESET_CYC), .TW(TW)) u_ctrl (
    .clk, .rstN, .startReq, .timeoutLimit,
    .measDone, .diffBad, .divDone, .strb,
    .chipResetN, .currentHold, .calBusy, .calDone,
    .errBadDiff, .errTimeout
  );

  rampcal_dp #(.PW(PW), .DW(DW)) u_dp (
    .clk, .rstN, .strb, .tachIn, .desiredDiff,
    .measDone, .diffBad, .divDone, .rampPwm, .dutyWord
  );

endmodule

// File: rtl/rampcal_checks.sv
module rampcal_checks #(
  parameter int CLK_HZ = 10_000_000,
  parameter int DW     = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          chipResetN,
  input logic          currentHold,
  input logic          calBusy,
  input logic          calDone,
  input logic          errBadDiff,
  input logic          errTimeout,
  input logic [DW-1:0] dutyWord
);

  localparam int RAW_CYC   = (CLK_HZ + 199_999) / 200_000;
  localparam int RESET_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  int lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowRun <= 0;
    else if (!chipResetN) lowRun <= lowRun + 1;
    else                  lowRun <= 0;
  end

  assert_rst_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= RESET_CYC);

  assert_rst_in_run_R1: assert property (@(posedge clk) disable iff (!rstN)
    !chipResetN |-> calBusy);

  assert_hold_in_rst_R2: assert property (@(posedge clk) disable iff (!rstN)
    !chipResetN |-> currentHold);

  assert_half_in_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> dutyWord == HALF);

  assert_bad_half_R7: assert property (@(posedge clk) disable iff (!rstN)
    errBadDiff |-> (calDone && !errTimeout && dutyWord == HALF));

  assert_timeout_half_R8: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> (calDone && dutyWord == HALF));

  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> $past(calBusy));

  assert_no_second_rst_R9: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && chipResetN) |=> chipResetN);

endmodule

bind rampcal_top rampcal_checks #(.CLK_HZ(CLK_HZ), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .chipResetN(chipResetN), .currentHold(currentHold),
  .calBusy(calBusy), .calDone(calDone), .errBadDiff(errBadDiff),
  .errTimeout(errTimeout), .dutyWord(dutyWord)
);

// File: tb/sim_rampcal_top.sv
module sim_rampcal_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int PW = 16, DW = 8, TW = 20;
  localparam int EXP_RST  = (CLK_HZ + 199_999) / 200_000;
  localparam int HALF_VAL = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          tachIn = 1'b0;
  logic [PW-1:0] desiredDiff = '0;
  logic [TW-1:0] timeoutLimit = TW'(2000);
  logic          chipResetN, currentHold, rampPwm, calBusy, calDone;
  logic          errBadDiff, errTimeout;
  logic [DW-1:0] dutyWord;

  int checks = 0;
  int errors = 0;
  int lowCnt = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rampcal_top #(.CLK_HZ(CLK_HZ), .PW(PW), .DW(DW), .TW(TW)) u0 (
    .clk, .rstN, .startReq, .tachIn, .desiredDiff, .timeoutLimit,
    .chipResetN, .currentHold, .rampPwm, .dutyWord, .calBusy, .calDone,
    .errBadDiff, .errTimeout
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock reference comparison of run-level outputs (R2) and reset time (R1)
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (!chipResetN) lowCnt++;
      if (calBusy) chk("R2 hold/half", {currentHold, dutyWord}, {1'b1, 8'd128});
      else         chk("R2 hold off", int'(currentHold), 0);
    end
    if (cycles == 200_000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic runCal(input string tag, input int desired, input int pa,
                        input int pb, input int nEdges, input bit glitch,
                        input bit restartMid);
    int diff, expDuty, waitN, highs, gap;
    bit expBad, expTo;
    diff  = pa - pb;
    expTo = (nEdges < 3);
    expBad = !expTo && (diff <= 0);
    if (expTo || expBad) expDuty = HALF_VAL;
    else begin
      expDuty = desired * HALF_VAL / diff;
      if (expDuty > 255) expDuty = 255;
    end
    desiredDiff = PW'(desired);
    lowCnt = 0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (glitch) begin   // R4: edge inside reset hold must be ignored
      repeat (5) @(negedge clk);
      tachIn = 1'b1;
      repeat (3) @(negedge clk);
      tachIn = 1'b0;
    end
    while (!chipResetN) @(negedge clk);
    chk("R1 reset width", lowCnt, EXP_RST);
    repeat (40) @(negedge clk);
    for (int e = 0; e < nEdges; e++) begin
      tachIn = 1'b1;
      repeat (4) @(negedge clk);
      tachIn = 1'b0;
      gap = (e == 0) ? pa : pb;
      if (e < nEdges - 1) begin
        if (restartMid && e == 1) begin
          startReq = 1'b1;
          @(negedge clk);
          startReq = 1'b0;
          repeat (gap - 5) @(negedge clk);
        end else begin
          repeat (gap - 4) @(negedge clk);
        end
      end
    end
    waitN = 0;
    while (!(calDone && !calBusy) && waitN < 5000) begin
      @(negedge clk);
      waitN++;
    end
    chk({tag, " R9 done"}, int'(calDone), 1);
    chk({tag, " R8 timeout flag"}, int'(errTimeout), int'(expTo));
    chk({tag, " R7 bad flag"}, int'(errBadDiff), int'(expBad));
    chk({tag, " duty"}, int'(dutyWord), expDuty);
    chk({tag, " R9 single reset"}, lowCnt, EXP_RST);
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (rampPwm) highs++;
      @(negedge clk);
    end
    chk({tag, " R3 pwm high"}, highs, expDuty);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 chipResetN", int'(chipResetN), 1);
    chk("R10 busy/done", {calBusy, calDone, currentHold}, 0);
    chk("R10 errors", {errBadDiff, errTimeout}, 0);
    chk("R10 duty", int'(dutyWord), HALF_VAL);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 duty after release", int'(dutyWord), HALF_VAL);

    runCal("R5 nominal", 10, 300, 280, 3, 1'b0, 1'b0);   // 1280/20 = 64
    runCal("R4 glitch", 7, 200, 170, 3, 1'b1, 1'b0);     // 896/30 = 29
    runCal("R6 saturate", 30, 400, 390, 3, 1'b0, 1'b0);  // 384 -> 255
    runCal("R5 zero desired", 0, 300, 280, 3, 1'b0, 1'b0);
    runCal("R7 negative", 10, 250, 260, 3, 1'b0, 1'b0);
    runCal("R7 zero diff", 10, 250, 250, 3, 1'b0, 1'b0);
    runCal("R8 two edges", 10, 300, 280, 2, 1'b0, 1'b0);
    runCal("R9 restart ignored", 10, 300, 280, 3, 1'b0, 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule